// File: doc/BRIEF.md
# Bitfield Manipulation Unit

This unit performs four operations on a contiguous bit field of a 32-bit word. A field is named by the position of its lowest bit and by its width. The four operations are:

- a signed extract, which pulls the field out of the source word and sign-extends it;
- an unsigned extract, which pulls the field out and zero-extends it;
- a clear, which zeroes the field inside the destination word;
- an insert, which writes the low bits of the source into the field of the destination word.

One mask generator serves all four operations. It also decides whether the lsb/width pair names a legal field.

The unit is a pure datapath stage for an execute pipeline. An operation is presented together with `in_valid`, and its result appears one clock later with `out_valid`. A pair that does not describe a field inside the word does not produce a result. Instead the unit raises `out_illegal` together with `out_valid` and returns zero. The unit produces no arithmetic or condition flags.

Top module: `bitfield_unit`

## Requirements
- R1: With `in_op` = 2'b00 (signed extract), the result holds source bits lsb..lsb+width-1 in bits 0..width-1, and every higher bit equals source bit lsb+width-1.
- R2: With `in_op` = 2'b01 (unsigned extract), the result holds the same field in bits 0..width-1, and every higher bit is zero.
- R3: With `in_op` = 2'b10 (clear), the result equals the destination operand with bits lsb..lsb+width-1 forced to zero.
- R4: With `in_op` = 2'b11 (insert), the result equals the destination operand with bits lsb..lsb+width-1 replaced by source bits 0..width-1.
- R5: A width of zero, or a width larger than 32 minus lsb, is illegal. In that case `out_illegal` is 1 in the same cycle as `out_valid`, and `out_result` is zero.
- R6: `out_valid` is high exactly in the cycle after each cycle where `in_valid` is high. `out_illegal` is never high while `out_valid` is low.
- R7: While `rst_n` is low, `out_valid`, `out_illegal` and `out_result` are all zero.
- R8: Width 32 at lsb 0 is legal. An extract of either kind then returns the whole source word, and an insert also returns the whole source word.
- R9: In a cycle after one with `in_valid` low, `out_result` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 2 | Operation select: 00 signed extract, 01 unsigned extract, 10 clear, 11 insert |
| in_src | input | 32 | Source operand |
| in_dst | input | 32 | Destination (old value) operand |
| in_lsb | input | 5 | Lowest bit position of the field |
| in_width | input | 6 | Field width in bits |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_result | output | 32 | Operation result, zero when illegal |
| out_illegal | output | 1 | Illegal lsb/width pair, qualified by `out_valid` |

## Verification
The assertions assume that the operand, lsb, width and op inputs are known values whenever `in_valid` is high. They also assume that `in_valid` itself is never unknown after reset. The bench drives every input from a task on the falling edge and returns `in_valid` to zero between operations or holds it for back-to-back runs. Operand values are therefore never left floating while the strobe is high. The width port can carry values from 33 to 63. The stimulus deliberately includes zero widths and widths that overrun bit 31, so that R5 is reached from both sides of the legal range.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned LSB_W  = $clog2(DATA_W);
  localparam int unsigned WID_W  = LSB_W + 1;

  typedef enum logic [1:0] {
    OP_SEXT  = 2'b00,
    OP_UEXT  = 2'b01,
    OP_CLEAR = 2'b10,
    OP_INS   = 2'b11
  } bf_op_e;
endpackage

// File: rtl/bfu_mask_gen.sv
module bfu_mask_gen #(
  parameter int unsigned DW   = 32,
  parameter int unsigned LSBW = $clog2(DW),
  parameter int unsigned WW   = LSBW + 1
) (
  input  logic [LSBW-1:0] lsb,
  input  logic [WW-1:0]   width,
  output logic [DW-1:0]   low_mask,
  output logic [DW-1:0]   field_mask,
  output logic            legal
);
  localparam int unsigned RW = WW + 1;
  logic [RW-1:0] room;

  always_comb begin
    // a shift by DW or more yields zero, so width == DW gives all ones
    low_mask   = ~({DW{1'b1}} << width);
    field_mask = low_mask << lsb;
    room       = RW'(DW) - RW'(lsb);
    legal      = (width != '0) && (RW'(width) <= room);
  end
endmodule

// File: rtl/bfu_extract.sv
module bfu_extract #(
  parameter int unsigned DW   = 32,
  parameter int unsigned LSBW = $clog2(DW),
  parameter int unsigned WW   = LSBW + 1
) (
  input  logic [DW-1:0]   src,
  input  logic [LSBW-1:0] lsb,
  input  logic [WW-1:0]   width,
  input  logic [DW-1:0]   low_mask,
  input  logic            sign_en,
  output logic [DW-1:0]   field_out
);
  logic [DW-1:0]   aligned;
  logic [WW-1:0]   wm1;
  logic [LSBW-1:0] top_idx;
  logic            sign_bit;

  always_comb begin
    aligned  = src >> lsb;
    wm1      = width - WW'(1);
    top_idx  = wm1[LSBW-1:0];
    sign_bit = sign_en & aligned[top_idx];
    field_out = (aligned & low_mask) | ({DW{sign_bit}} & ~low_mask);
  end
endmodule

// File: rtl/bfu_merge.sv
module bfu_merge #(
  parameter int unsigned DW   = 32,
  parameter int unsigned LSBW = $clog2(DW)
) (
  input  logic [DW-1:0]   src,
  input  logic [DW-1:0]   dst,
  input  logic [LSBW-1:0] lsb,
  input  logic [DW-1:0]   field_mask,
  input  logic            ins_en,
  output logic [DW-1:0]   merged
);
  logic [DW-1:0] kept;
  logic [DW-1:0] placed;

  always_comb begin
    kept   = dst & ~field_mask;
    placed = (src << lsb) & field_mask;
    merged = ins_en ? (kept | placed) : kept;
  end
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
  import bfu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        in_op,
  input  logic [DATA_W-1:0] in_src,
  input  logic [DATA_W-1:0] in_dst,
  input  logic [LSB_W-1:0]  in_lsb,
  input  logic [WID_W-1:0]  in_width,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result,
  output logic              out_illegal
);
  bf_op_e            op;
  logic [DATA_W-1:0] low_mask, field_mask;
  logic              legal;
  logic [DATA_W-1:0] ext_val, mrg_val;
  logic [DATA_W-1:0] res_d, res_q;
  logic              vld_d, vld_q, ill_d, ill_q;
  logic              res_en;

  assign op = bf_op_e'(in_op);

  bfu_mask_gen #(.DW(DATA_W), .LSBW(LSB_W), .WW(WID_W)) u_mask (
    .lsb(in_lsb), .width(in_width),
    .low_mask(low_mask), .field_mask(field_mask), .legal(legal)
  );

  bfu_extract #(.DW(DATA_W), .LSBW(LSB_W), .WW(WID_W)) u_ext (
    .src(in_src), .lsb(in_lsb), .width(in_width),
    .low_mask(low_mask), .sign_en(op == OP_SEXT), .field_out(ext_val)
  );

  bfu_merge #(.DW(DATA_W), .LSBW(LSB_W)) u_mrg (
    .src(in_src), .dst(in_dst), .lsb(in_lsb),
    .field_mask(field_mask), .ins_en(op == OP_INS), .merged(mrg_val)
  );

  // next state
  always_comb begin
    res_en = in_valid;
    vld_d  = in_valid;
    ill_d  = in_valid & ~legal;
    if (!legal)
      res_d = '0;
    else if (op == OP_SEXT || op == OP_UEXT)
      res_d = ext_val;
    else
      res_d = mrg_val;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      ill_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= vld_d;
      ill_q <= ill_d;
      if (res_en) res_q <= res_d;
    end
  end

  assign out_valid   = vld_q;
  assign out_illegal = ill_q;
  assign out_result  = res_q;
endmodule

// File: rtl/bitfield_unit_checker.sv
module bitfield_unit_checker
  import bfu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        in_op,
  input logic [DATA_W-1:0] in_src,
  input logic [LSB_W-1:0]  in_lsb,
  input logic [WID_W-1:0]  in_width,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_result,
  input logic              out_illegal
);
  p_valid_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_illegal_qualified_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> out_valid);
  p_illegal_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> (out_result == '0));
  p_zero_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_width == '0) |=> out_illegal);
  p_full_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_lsb == '0 && in_width == WID_W'(DATA_W) && in_op != 2'b10)
      |=> (!out_illegal && out_result == $past(in_src)));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_result));
  always_comb begin
    if (!rst_n) begin
      a_reset_r7: assert (!out_valid && !out_illegal && out_result == '0);
    end
  end
endmodule

bind bitfield_unit bitfield_unit_checker u_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
  .in_src(in_src), .in_lsb(in_lsb), .in_width(in_width),
  .out_valid(out_valid), .out_result(out_result), .out_illegal(out_illegal)
);

// File: tb/bitfield_unit_bench.sv
module bitfield_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  in_op;
  logic [31:0] in_src, in_dst;
  logic [4:0]  in_lsb;
  logic [5:0]  in_width;
  logic        out_valid, out_illegal;
  logic [31:0] out_result;

  typedef struct {
    logic [31:0] res;
    logic        ill;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          n_checks = 0;
  int          n_fail   = 0;
  logic        exp_vld  = 1'b0;
  logic [31:0] last_res = '0;
  bit          done     = 0;

  always #2.5 clk = ~clk;

  bitfield_unit u_bitfield_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_src(in_src), .in_dst(in_dst), .in_lsb(in_lsb), .in_width(in_width),
    .out_valid(out_valid), .out_result(out_result), .out_illegal(out_illegal)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [1:0] op, input logic [31:0] s,
                                 input logic [31:0] d, input int lsb, input int w);
    exp_t e;
    e.res = '0;
    e.ill = (w == 0) || (w > 32 - lsb);
    case (op)
      2'b00: e.tag = "R1";
      2'b01: e.tag = "R2";
      2'b10: e.tag = "R3";
      default: e.tag = "R4";
    endcase
    if (e.ill) begin
      e.tag = "R5";
      return e;
    end
    if (lsb == 0 && w == 32 && op != 2'b10) e.tag = "R8";
    for (int i = 0; i < 32; i++) begin
      case (op)
        2'b00: e.res[i] = (i < w) ? s[lsb+i] : s[lsb+w-1];
        2'b01: e.res[i] = (i < w) ? s[lsb+i] : 1'b0;
        2'b10: e.res[i] = (i >= lsb && i < lsb + w) ? 1'b0 : d[i];
        default: e.res[i] = (i >= lsb && i < lsb + w) ? s[i-lsb] : d[i];
      endcase
    end
    return e;
  endfunction

  task automatic drive(input logic [1:0] op, input logic [31:0] s,
                       input logic [31:0] d, input int lsb, input int w,
                       input bit keep = 0);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_src = s; in_dst = d;
    in_lsb = 5'(lsb); in_width = 6'(w);
    sb.push_back(model(op, s, d, lsb, w));
    if (!keep) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // bench's own copy of the strobe seen at the edge
  always @(posedge clk) exp_vld <= rst_n ? in_valid : 1'b0;

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(out_valid == exp_vld, "R6 valid timing", 32'(out_valid), 32'(exp_vld));
      if (!out_valid)
        check(!out_illegal, "R6 illegal without valid", 32'(out_illegal), 0);
      if (out_valid) begin
        if (sb.size() == 0) begin
          check(0, "R6 unexpected result", out_result, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(out_result == e.res, e.tag, out_result, e.res);
          check(out_illegal == e.ill, {e.tag, " illegal flag"},
                32'(out_illegal), 32'(e.ill));
          last_res = e.res;
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : stim
    rst_n = 1'b0; in_valid = 1'b0; in_op = '0; in_src = '0; in_dst = '0;
    in_lsb = '0; in_width = '0;
    repeat (3) @(negedge clk);
    // R7 reset state
    check(!out_valid && !out_illegal && out_result == '0, "R7 reset",
          out_result, 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 signed extract, 4 bits at 20, negative and positive
    drive(2'b00, 32'h00F0_0000, 32'h0, 20, 4);
    drive(2'b00, 32'h0070_0000, 32'h0, 20, 4);
    drive(2'b00, 32'h8000_0000, 32'h0, 31, 1);
    // R2 unsigned extract, 10 bits at 9
    drive(2'b01, 32'hFFFF_FFFF, 32'h0, 9, 10);
    drive(2'b01, 32'hDEAD_BEEF, 32'h0, 31, 1);
    // R3 clear 12 bits at 8
    drive(2'b10, 32'h0, 32'hFFFF_FFFF, 8, 12);
    drive(2'b10, 32'h0, 32'h1234_5678, 0, 32);
    // R4 insert 12 bits at 8
    drive(2'b11, 32'h0000_0ABC, 32'h1111_1111, 8, 12);
    drive(2'b11, 32'hFFFF_FFFF, 32'h0, 31, 1);
    // R8 full word
    drive(2'b00, 32'h8765_4321, 32'h0, 0, 32);
    drive(2'b01, 32'h8765_4321, 32'h0, 0, 32);
    drive(2'b11, 32'hCAFE_F00D, 32'h0123_4567, 0, 32);
    // R5 illegal pairs
    drive(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4, 0);
    drive(2'b11, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 32);
    drive(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 20, 13);
    drive(2'b10, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 63);
    drive(2'b01, 32'hA5A5_A5A5, 32'h0, 3, 7);
    // R9 hold across idle cycles
    repeat (4) @(negedge clk);
    check(out_result == last_res, "R9 hold", out_result, last_res);
    // back-to-back random mix
    for (int k = 0; k < 400; k++) begin
      int w;
      int l;
      l = int'($urandom_range(0, 31));
      w = (k % 9 == 0) ? int'($urandom_range(0, 63)) : int'($urandom_range(1, 32 - l));
      drive(2'($urandom), $urandom, $urandom, l, w, (k % 3) != 0);
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(out_result == last_res, "R9 hold after burst", out_result, last_res);
    check(sb.size() == 0, "R6 all results returned", 32'(sb.size()), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule